// File: doc/BRIEF.md
# Multiplexed-Address Row-Buffered Memory Array

This block models a small dynamic-style storage array of supercells arranged as rows and columns. A requester reaches a supercell in two steps over one narrow address bus. First it asserts the row strobe with a row index. That copies the whole row into an internal row buffer and leaves the row open. Then it asserts the column strobe with a column index. That reads one supercell out of the buffer, or writes one into it. Every data transfer passes through the row buffer. The array itself is written only when a row is closed, replaced by a new row, or refreshed.

Closing a row needs either a new row strobe or an explicit close request. Both write the buffer back to the array. When no row is open, the requester may ask for a refresh. Each accepted refresh passes one row from the array back into the array. A counter selects that row; it advances by one per refresh and wraps after the last row. Read data is registered and is qualified by a valid flag one clock after the column strobe. A column strobe with no open row does nothing except pulse an error flag.

When several requests arrive in one cycle, the row strobe wins, then the column strobe, then close, then refresh. The row count, column count and supercell width are parameters. The address bus is wide enough for the larger of the row index and the column index. Indices sent on the bus must lie within range.

Top module: `mux_row_mem`

## Requirements
- R1: After reset, rdata, rvalid, col_err, row_open and refresh_ack are 0, and every supercell reads back as 0.
- R2: A row strobe with row index i sets row_open in the next cycle. A following column strobe with we=0 and column index j makes rvalid 1, with rdata holding supercell (i,j), in the cycle after that strobe. rvalid is 0 in every other cycle.
- R3: A column strobe with we=1 on an open row replaces only the selected column's byte in the buffer with wdata, and leaves rvalid at 0. Later reads of that open row return the new byte in that column and the old bytes in the other columns.
- R4: A row strobe while a different row is open writes the buffer back to the array. Data written into the old row is then returned when that row is opened again later.
- R5: A column strobe, read or write, with no open row is ignored. col_err is 1 for exactly the following cycle, rvalid stays 0, and no stored byte changes.
- R6: A close request on an open row writes the buffer back to the array and clears row_open in the next cycle. A close request with no open row has no effect.
- R7: A refresh request is accepted only when no row is open and no row strobe, column strobe or close request is present. An accepted request makes refresh_ack 1 for the following cycle, with refresh_row giving the row refreshed. A request while a row is open leaves refresh_ack at 0.
- R8: The refresh row counter starts at 0 after reset and advances by one per accepted refresh, wrapping from ROWS-1 to 0. Refresh leaves all stored data unchanged.
- R9: Priority within one cycle is row strobe, then column strobe, then close, then refresh. A column strobe arriving together with a row strobe is dropped: no rvalid and no col_err. A column read arriving together with a close request is served, and the row stays open.
- R10: A row strobe naming the row that is already open keeps the buffer's contents, including bytes written since the row was opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras | input | 1 | Row strobe: open the row given on addr |
| cas | input | 1 | Column strobe: access the column given on addr |
| we | input | 1 | With cas: 1 writes wdata, 0 reads |
| close_req | input | 1 | Write back and close the open row |
| refresh_req | input | 1 | Request one refresh step |
| addr | input | AW | Multiplexed row or column index, AW = clog2(max(ROWS,COLS)) |
| wdata | input | WIDTH | Byte written by a column write |
| rdata | output | WIDTH | Registered read data |
| rvalid | output | 1 | rdata valid for this cycle |
| col_err | output | 1 | Column strobe arrived with no open row |
| row_open | output | 1 | A row is held in the buffer |
| refresh_ack | output | 1 | A refresh step was accepted on the last edge |
| refresh_row | output | clog2(ROWS) | Row handled by the last refresh step |

## Verification
The assertions check on every cycle the following: a read-valid is always preceded by a column read on an open row; an error pulse is always preceded by a column strobe with no row open; refresh is acknowledged only from the closed state; a row strobe always leaves a row open; the refresh counter moves only on an accepted step. Several behaviours only the directed scenarios can show, because each needs data followed across several commands. These are: write-back when a row is replaced or closed, the update of a single column, buffer contents kept when the open row is reopened, the counter wrapping through every row, and data left intact by refresh.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

  typedef enum logic [2:0] {
    MRM_IDLE,
    MRM_OPEN,
    MRM_COL,
    MRM_COL_ERR,
    MRM_CLOSE,
    MRM_REFRESH
  } mrm_cmd_e;

  // Priority: row strobe, column strobe, close, refresh.
  function automatic mrm_cmd_e mrm_decode(input logic ras, input logic cas,
                                          input logic close_r, input logic ref_r,
                                          input logic is_open);
    if (ras)          return MRM_OPEN;
    else if (cas)     return is_open ? MRM_COL : MRM_COL_ERR;
    else if (close_r) return is_open ? MRM_CLOSE : MRM_IDLE;
    else if (ref_r)   return is_open ? MRM_IDLE : MRM_REFRESH;
    else              return MRM_IDLE;
  endfunction

  function automatic int mrm_addr_bits(input int rows, input int cols);
    int m;
    m = (rows > cols) ? rows : cols;
    return (m > 2) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/mrm_array.sv
module mrm_array #(
  parameter int ROWS = 4,
  parameter int RW   = 2,
  parameter int ROWW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   rd_row,
  output logic [ROWW-1:0] rd_data,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [ROWW-1:0] wr_data
);

  logic [ROWW-1:0] cells [ROWS];

  assign rd_data = cells[rd_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (wr_en) begin
      cells[wr_row] <= wr_data;
    end
  end

endmodule

// File: rtl/mrm_rowbuf.sv
module mrm_rowbuf #(
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  parameter int CW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [COLS*WIDTH-1:0] load_data,
  input  logic                  col_en,
  input  logic                  col_we,
  input  logic [CW-1:0]         col,
  input  logic [WIDTH-1:0]      wdata,
  output logic [COLS*WIDTH-1:0] row_q,
  output logic [WIDTH-1:0]      rdata,
  output logic                  rvalid
);

  logic [WIDTH-1:0] slot [COLS];

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_slot
      assign slot[c] = row_q[c*WIDTH +: WIDTH];
      always_ff @(posedge clk) begin
        if (!rst_n)
          row_q[c*WIDTH +: WIDTH] <= '0;
        else if (load_en)
          row_q[c*WIDTH +: WIDTH] <= load_data[c*WIDTH +: WIDTH];
        else if (col_en && col_we && (col == CW'(c)))
          row_q[c*WIDTH +: WIDTH] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= col_en && !col_we;
      if (col_en && !col_we) rdata <= slot[col];
    end
  end

  assert_write_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_en && col_we) |=> !rvalid);

endmodule

// File: rtl/mrm_ctrl.sv
module mrm_ctrl
  import mrm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int RW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras,
  input  logic          cas,
  input  logic          close_req,
  input  logic          refresh_req,
  input  logic [RW-1:0] row_addr,
  output logic          open_q,
  output logic          col_fire,
  output logic          load_en,
  output logic          arr_wr_en,
  output logic          ref_fire,
  output logic [RW-1:0] rd_row,
  output logic [RW-1:0] wr_row,
  output logic          col_err,
  output logic          ref_ack,
  output logic [RW-1:0] ref_row
);

  mrm_cmd_e      cmd;
  logic [RW-1:0] open_row;
  logic [RW-1:0] ref_ctr;
  logic          same_row;
  logic          wb_en;

  assign cmd      = mrm_decode(ras, cas, close_req, refresh_req, open_q);
  assign same_row = open_q && (row_addr == open_row);
  assign col_fire = (cmd == MRM_COL);
  assign ref_fire = (cmd == MRM_REFRESH);
  assign load_en  = (cmd == MRM_OPEN) && !same_row;
  assign wb_en    = ((cmd == MRM_OPEN) && open_q) || (cmd == MRM_CLOSE);
  assign arr_wr_en = wb_en || ref_fire;
  assign rd_row   = ref_fire ? ref_ctr : row_addr;
  assign wr_row   = ref_fire ? ref_ctr : open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      open_row <= '0;
      ref_ctr  <= '0;
      ref_row  <= '0;
      col_err  <= 1'b0;
      ref_ack  <= 1'b0;
    end else begin
      col_err <= (cmd == MRM_COL_ERR);
      ref_ack <= ref_fire;
      if (cmd == MRM_OPEN) begin
        open_q   <= 1'b1;
        open_row <= row_addr;
      end else if (cmd == MRM_CLOSE) begin
        open_q <= 1'b0;
      end
      if (ref_fire) begin
        ref_row <= ref_ctr;
        ref_ctr <= (ref_ctr == RW'(ROWS-1)) ? '0 : ref_ctr + 1'b1;
      end
    end
  end

  assert_ctr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_fire |=> $stable(ref_ctr));

endmodule

// File: rtl/mux_row_mem.sv
module mux_row_mem
  import mrm_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  parameter int AW    = mrm_addr_bits(ROWS, COLS),
  parameter int RW    = (ROWS > 2) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras,
  input  logic             cas,
  input  logic             we,
  input  logic             close_req,
  input  logic             refresh_req,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid,
  output logic             col_err,
  output logic             row_open,
  output logic             refresh_ack,
  output logic [RW-1:0]    refresh_row
);

  localparam int CW   = (COLS > 2) ? $clog2(COLS) : 1;
  localparam int ROWW = COLS * WIDTH;

  logic [RW-1:0]   row_addr;
  logic [CW-1:0]   col_addr;
  logic            col_fire, load_en, arr_wr_en, ref_fire;
  logic [RW-1:0]   rd_row, wr_row;
  logic [ROWW-1:0] arr_rd, buf_row, arr_wr_data;

  assign row_addr    = addr[RW-1:0];
  assign col_addr    = addr[CW-1:0];
  assign arr_wr_data = ref_fire ? arr_rd : buf_row;

  mrm_ctrl #(.ROWS(ROWS), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .close_req(close_req),
    .refresh_req(refresh_req), .row_addr(row_addr), .open_q(row_open),
    .col_fire(col_fire), .load_en(load_en), .arr_wr_en(arr_wr_en),
    .ref_fire(ref_fire), .rd_row(rd_row), .wr_row(wr_row),
    .col_err(col_err), .ref_ack(refresh_ack), .ref_row(refresh_row)
  );

  mrm_array #(.ROWS(ROWS), .RW(RW), .ROWW(ROWW)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_row(rd_row), .rd_data(arr_rd),
    .wr_en(arr_wr_en), .wr_row(wr_row), .wr_data(arr_wr_data)
  );

  mrm_rowbuf #(.COLS(COLS), .WIDTH(WIDTH), .CW(CW)) u_rowbuf (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(arr_rd),
    .col_en(col_fire), .col_we(we), .col(col_addr), .wdata(wdata),
    .row_q(buf_row), .rdata(rdata), .rvalid(rvalid)
  );

  assert_rvalid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(cas && !we && !ras && row_open));

  assert_err_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_err |-> $past(cas && !ras && !row_open));

  assert_ref_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ack |-> $past(refresh_req && !row_open && !ras && !cas && !close_req));

  assert_open_after_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ras |=> row_open);

endmodule

// File: tb/mux_row_mem_tb.sv
module mux_row_mem_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ras = 0, cas = 0, we = 0, close_req = 0, refresh_req = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       rvalid, col_err, row_open, refresh_ack;
  logic [1:0] refresh_row;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mux_row_mem u_dut (
    .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we),
    .close_req(close_req), .refresh_req(refresh_req), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .col_err(col_err),
    .row_open(row_open), .refresh_ack(refresh_ack), .refresh_row(refresh_row)
  );

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'(8'h40 + r * 16 + c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic open_row(input int r);
    addr = 2'(r); ras = 1; cyc; ras = 0;
  endtask

  task automatic close_row;
    close_req = 1; cyc; close_req = 0;
  endtask

  task automatic wr_col(input int c, input logic [7:0] d);
    addr = 2'(c); cas = 1; we = 1; wdata = d; cyc; cas = 0; we = 0;
  endtask

  task automatic rd_chk(input string req, input int c, input logic [7:0] exp);
    addr = 2'(c); cas = 1; we = 0; cyc; cas = 0;
    chk(req, {31'd0, rvalid}, 32'd1);
    chk(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 rdata", {24'd0, rdata}, 0);
    chk("R1 rvalid", {31'd0, rvalid}, 0);
    chk("R1 col_err", {31'd0, col_err}, 0);
    chk("R1 row_open", {31'd0, row_open}, 0);
    chk("R1 refresh_ack", {31'd0, refresh_ack}, 0);
    open_row(3);
    rd_chk("R1 zero cell", 3, 8'h00);
    close_row;
  endtask

  task automatic t_fill_read;
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      chk("R2 row_open", {31'd0, row_open}, 1);
      for (int c = 0; c < 4; c++) begin
        wr_col(c, pat(r, c));
        chk("R3 write no rvalid", {31'd0, rvalid}, 0);
      end
    end
    close_row;
    open_row(2);
    rd_chk("R2 read (2,1)", 1, pat(2, 1));
    cyc;
    chk("R2 rvalid single", {31'd0, rvalid}, 0);
    open_row(0);
    rd_chk("R4 row 0 written back", 3, pat(0, 3));
  endtask

  task automatic t_col_write;
    open_row(1);
    wr_col(2, 8'hAA);
    rd_chk("R3 new byte", 2, 8'hAA);
    rd_chk("R3 col0 kept", 0, pat(1, 0));
    rd_chk("R3 col1 kept", 1, pat(1, 1));
    rd_chk("R3 col3 kept", 3, pat(1, 3));
    wr_col(0, 8'h5C);
    open_row(1);
    rd_chk("R10 reopen keeps col2", 2, 8'hAA);
    rd_chk("R10 reopen keeps col0", 0, 8'h5C);
  endtask

  task automatic t_close;
    close_row;
    chk("R6 closed", {31'd0, row_open}, 0);
    close_row;
    chk("R6 idle close", {31'd0, row_open}, 0);
    open_row(3);
    open_row(1);
    rd_chk("R6 close wrote back", 0, 8'h5C);
    rd_chk("R4 written back", 2, 8'hAA);
    close_row;
  endtask

  task automatic t_col_err;
    addr = 2'd1; cas = 1; we = 0; cyc; cas = 0;
    chk("R5 col_err", {31'd0, col_err}, 1);
    chk("R5 no rvalid", {31'd0, rvalid}, 0);
    cyc;
    chk("R5 col_err pulse", {31'd0, col_err}, 0);
    addr = 2'd1; cas = 1; we = 1; wdata = 8'hEE; cyc; cas = 0; we = 0;
    chk("R5 col_err write", {31'd0, col_err}, 1);
    chk("R5 still closed", {31'd0, row_open}, 0);
    open_row(1);
    rd_chk("R5 data untouched", 1, pat(1, 1));
  endtask

  task automatic t_refresh;
    refresh_req = 1; cyc; refresh_req = 0;
    chk("R7 refused while open", {31'd0, refresh_ack}, 0);
    close_row;
    refresh_req = 1; cyc; refresh_req = 0;
    chk("R7 ack", {31'd0, refresh_ack}, 1);
    chk("R8 first row", {30'd0, refresh_row}, 0);
    cyc;
    chk("R7 ack pulse", {31'd0, refresh_ack}, 0);
    for (int k = 1; k <= 4; k++) begin
      refresh_req = 1; cyc; refresh_req = 0;
      chk("R8 ack", {31'd0, refresh_ack}, 1);
      chk("R8 counter", {30'd0, refresh_row}, 32'(k % 4));
    end
    open_row(3);
    rd_chk("R8 data kept row3", 2, pat(3, 2));
    open_row(0);
    rd_chk("R8 data kept row0", 1, pat(0, 1));
    open_row(1);
    rd_chk("R8 data kept row1", 2, 8'hAA);
    close_row;
  endtask

  task automatic t_priority;
    addr = 2'd2; ras = 1; cas = 1; cyc; ras = 0; cas = 0;
    chk("R9 ras wins open", {31'd0, row_open}, 1);
    chk("R9 cas dropped rvalid", {31'd0, rvalid}, 0);
    chk("R9 cas dropped err", {31'd0, col_err}, 0);
    addr = 2'd1; cas = 1; close_req = 1; cyc; cas = 0; close_req = 0;
    chk("R9 cas over close", {31'd0, rvalid}, 1);
    chk("R9 cas data", {24'd0, rdata}, {24'd0, pat(2, 1)});
    chk("R9 row stays open", {31'd0, row_open}, 1);
    close_row;
    close_req = 1; refresh_req = 1; cyc; close_req = 0; refresh_req = 0;
    chk("R9 close over refresh", {31'd0, refresh_ack}, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc;
    t_reset;
    t_fill_read;
    t_col_write;
    t_close;
    t_col_err;
    t_refresh;
    t_priority;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule